// File: doc/BRIEF.md
# UART Interrupt Arbiter with Receive Timeout

This block gathers the interrupt sources of one UART channel, gates them with a 4-bit enable mask and reports only the most urgent one. The CPU reads an 8-bit status byte whose low nibble names the reported source, and an active-high interrupt line goes high whenever any enabled source is pending. The UART datapath supplies FIFO fill counts, error and modem-change pulses and register access strobes. The register decoder routes the status byte onto the bus.

The block owns the receive character timeout. A counter runs on the 16x bit tick while the receive FIFO holds data. It restarts at the middle of every received stop bit and at every receive data read. It fires after four character times, and the length of one character follows the current line settings.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the status byte is 0x01 with the enable mask at zero, and `irq_o` is low. The transmit-empty source is pending from reset, so enabling mask bit 1 alone gives status 0x02 at once.
- R2: Status bits 7:6 read 11 when `fifo_en_i` is 1 and 00 when it is 0. Bits 5:4 always read 0.
- R3: Status bits 3:0 hold one code, listed from highest to lowest priority: 0110 line error, 0100 receive data, 1100 receive timeout, 0010 transmit empty, 0000 modem change, 0001 none pending. Only the highest active source is shown, and receive data wins over timeout.
- R4: Mask bit 0 enables receive data and timeout, bit 1 transmit empty, bit 2 line error, and bit 3 modem change. A masked source is never reported, but it stays latched.
- R5: A pulse on any bit of `rx_err_i` latches the line error source. A pulse on `lsr_rd_i` clears it, but a new error in the same cycle wins.
- R6: The receive data source is active while `rx_cnt_i` is nonzero and, with FIFOs enabled, at least `rx_trig_i`. With FIFOs disabled a nonzero count is enough. It follows the count without latching.
- R7: A rising edge of `tx_empty_i` sets the transmit-empty source. `thr_wr_i` clears it and wins over a rising edge. `isr_rd_i` clears it only while 0010 is the reported code.
- R8: With FIFOs enabled and the receive FIFO not empty, the timeout source sets on the Nth tick after the last restart. N is 64 × (1 + 5 + `word_len_i` + `parity_en_i` + (`stop2_i` ? 2 : 1)).
- R9: `stop_ctr_i` and `rbr_rd_i` restart the timeout count. `rbr_rd_i` also clears a pending timeout.
- R10: The timeout never sets while `rx_cnt_i` is zero or FIFOs are disabled, and a pending timeout clears in that case.
- R11: A pulse on any bit of `msr_delta_i` latches the modem change source. `msr_rd_i` clears it, and a new change in the same cycle wins.
- R12: `irq_o` is high exactly when status bit 0 is 0.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | FIFO mode enabled |
| ier_i | input | 4 | Interrupt enable mask |
| rx_trig_i | input | CNT_W | Receive trigger level |
| rx_cnt_i | input | CNT_W | Receive FIFO fill count |
| rx_err_i | input | 4 | Receive error pulses (overrun, parity, framing, break) |
| tx_empty_i | input | 1 | Transmit FIFO or holding register empty |
| msr_delta_i | input | 4 | Modem line change pulses |
| tick16_i | input | 1 | 16x bit clock enable |
| word_len_i | input | 2 | Data bits minus 5 |
| parity_en_i | input | 1 | Parity bit present |
| stop2_i | input | 1 | Two stop bits |
| stop_ctr_i | input | 1 | Middle of a received stop bit |
| rbr_rd_i | input | 1 | Receive data read strobe |
| isr_rd_i | input | 1 | Status read strobe |
| lsr_rd_i | input | 1 | Line status read strobe |
| msr_rd_i | input | 1 | Modem status read strobe |
| thr_wr_i | input | 1 | Transmit data write strobe |
| isr_o | output | 8 | Interrupt status byte |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Random mixes of masks, FIFO counts, trigger levels, error, modem and access pulses are run against a bench model of the latches and the priority chain. These mixes tell apart the priority order, masking, and the cases where a set and a clear arrive in the same cycle. Directed runs cover the timeout under random line settings. They check the cycle just before and the cycle of expiry, which exposes off-by-one and character-length errors. Further directed runs show that a stop-bit restart pushes expiry back, that a data read clears the timeout, and that an empty FIFO never fires it.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  typedef enum logic [3:0] {
    IRQ_MODEM   = 4'b0000,
    IRQ_NONE    = 4'b0001,
    IRQ_TXEMPTY = 4'b0010,
    IRQ_RXDATA  = 4'b0100,
    IRQ_LINE    = 4'b0110,
    IRQ_RXTMO   = 4'b1100
  } irq_code_e;

  localparam int NSRC     = 5;
  localparam int MAX_BITS = 12;

  // index 0 is the highest priority
  localparam irq_code_e SRC_CODE [NSRC] = '{IRQ_LINE, IRQ_RXDATA, IRQ_RXTMO, IRQ_TXEMPTY, IRQ_MODEM};
  localparam int        SRC_IER  [NSRC] = '{2, 0, 0, 1, 3};

  function automatic logic [3:0] char_bits(logic [1:0] wl, logic par, logic stp);
    return 4'd6 + {2'b00, wl} + {3'b000, par} + (stp ? 4'd2 : 4'd1);
  endfunction
endpackage

// File: rtl/uart_irq_tmo.sv
module uart_irq_tmo
  import uart_irq_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int TMO_CHARS     = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       fifo_en_i,
  input  logic       rx_empty_i,
  input  logic       tick_i,
  input  logic [1:0] word_len_i,
  input  logic       parity_en_i,
  input  logic       stop2_i,
  input  logic       stop_ctr_i,
  input  logic       rbr_rd_i,
  output logic       tmo_o
);
  localparam int TMO_W = $clog2(TMO_CHARS * TICKS_PER_BIT * MAX_BITS + 1);

  logic [TMO_W-1:0] cnt_q, lim;
  logic             tmo_q;

  always_comb lim = TMO_W'(TMO_CHARS * TICKS_PER_BIT * int'(char_bits(word_len_i, parity_en_i, stop2_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else if (!fifo_en_i || rx_empty_i) begin
      cnt_q <= '0;
      tmo_q <= 1'b0;
    end else if (stop_ctr_i || rbr_rd_i) begin
      cnt_q <= '0;
      if (rbr_rd_i) tmo_q <= 1'b0;
    end else if (tick_i && !tmo_q) begin
      if (cnt_q >= lim - TMO_W'(1)) begin
        tmo_q <= 1'b1;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + TMO_W'(1);
      end
    end
  end

  assign tmo_o = tmo_q;

  a_r10_no_tmo_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_empty_i || !fifo_en_i) |=> !tmo_o);
  a_r9_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rbr_rd_i |=> !tmo_o);
  a_r8_fires_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_o) |-> $past(tick_i));
endmodule

// File: rtl/uart_irq_src.sv
module uart_irq_src (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] rx_err_i,
  input  logic       lsr_rd_i,
  input  logic [3:0] msr_delta_i,
  input  logic       msr_rd_i,
  input  logic       tx_empty_i,
  input  logic       thr_wr_i,
  input  logic       thre_rd_clr_i,
  output logic       line_o,
  output logic       thre_o,
  output logic       modem_o
);
  logic line_q, modem_q, thre_q, tx_empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q     <= 1'b0;
      modem_q    <= 1'b0;
      thre_q     <= 1'b1;
      tx_empty_q <= 1'b1;
    end else begin
      tx_empty_q <= tx_empty_i;
      if (|rx_err_i)    line_q <= 1'b1;
      else if (lsr_rd_i) line_q <= 1'b0;
      if (|msr_delta_i)  modem_q <= 1'b1;
      else if (msr_rd_i) modem_q <= 1'b0;
      if (thr_wr_i)                       thre_q <= 1'b0;
      else if (tx_empty_i && !tx_empty_q) thre_q <= 1'b1;
      else if (thre_rd_clr_i)             thre_q <= 1'b0;
    end
  end

  assign line_o  = line_q;
  assign thre_o  = thre_q;
  assign modem_o = modem_q;

  a_r5_line_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o && !lsr_rd_i) |=> line_o);
  a_r7_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_wr_i |=> !thre_o);
  a_r11_modem_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|msr_delta_i) |=> modem_o);
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [3:0]      ier_i,
  input  logic [NSRC-1:0] raw_i,
  output irq_code_e       code_o,
  output logic            irq_o
);
  logic [NSRC-1:0] act;

  for (genvar g = 0; g < NSRC; g++) begin : g_mask
    assign act[g] = raw_i[g] & ier_i[SRC_IER[g]];
  end

  always_comb begin
    code_o = IRQ_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (act[i]) code_o = SRC_CODE[i];
    end
  end

  assign irq_o = |act;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int FIFO_DEPTH    = 16,
  parameter int CNT_W         = $clog2(FIFO_DEPTH + 1),
  parameter int TICKS_PER_BIT = 16,
  parameter int TMO_CHARS     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic [3:0]       ier_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic [3:0]       rx_err_i,
  input  logic             tx_empty_i,
  input  logic [3:0]       msr_delta_i,
  input  logic             tick16_i,
  input  logic [1:0]       word_len_i,
  input  logic             parity_en_i,
  input  logic             stop2_i,
  input  logic             stop_ctr_i,
  input  logic             rbr_rd_i,
  input  logic             isr_rd_i,
  input  logic             lsr_rd_i,
  input  logic             msr_rd_i,
  input  logic             thr_wr_i,
  output logic [7:0]       isr_o,
  output logic             irq_o
);
  logic            rx_empty, rx_data, tmo, line_p, thre_p, modem_p;
  logic [NSRC-1:0] raw;
  irq_code_e       code;

  assign rx_empty = (rx_cnt_i == '0);
  assign rx_data  = !rx_empty && (!fifo_en_i || (rx_cnt_i >= rx_trig_i));

  uart_irq_tmo #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .TMO_CHARS    (TMO_CHARS)
  ) tmo_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fifo_en_i  (fifo_en_i),
    .rx_empty_i (rx_empty),
    .tick_i     (tick16_i),
    .word_len_i (word_len_i),
    .parity_en_i(parity_en_i),
    .stop2_i    (stop2_i),
    .stop_ctr_i (stop_ctr_i),
    .rbr_rd_i   (rbr_rd_i),
    .tmo_o      (tmo)
  );

  uart_irq_src src_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_err_i     (rx_err_i),
    .lsr_rd_i     (lsr_rd_i),
    .msr_delta_i  (msr_delta_i),
    .msr_rd_i     (msr_rd_i),
    .tx_empty_i   (tx_empty_i),
    .thr_wr_i     (thr_wr_i),
    .thre_rd_clr_i(isr_rd_i && (code == IRQ_TXEMPTY)),
    .line_o       (line_p),
    .thre_o       (thre_p),
    .modem_o      (modem_p)
  );

  assign raw = {modem_p, thre_p, tmo, rx_data, line_p};

  uart_irq_prio prio_i (
    .ier_i (ier_i),
    .raw_i (raw),
    .code_o(code),
    .irq_o (irq_o)
  );

  assign isr_o = {{2{fifo_en_i}}, 2'b00, code};

  a_r12_irq_vs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == !isr_o[0]);
  a_r3_line_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_p && ier_i[2]) |-> (isr_o[3:0] == IRQ_LINE));
  a_r4_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ier_i == 4'h0) |-> !irq_o);
  a_r2_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_o[5:4] == 2'b00);
endmodule

// File: tb/uart_irq_ctrl_tb_top.sv
module uart_irq_ctrl_tb_top;
  localparam int CNT_W = 5;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             fifo_en_i = 1'b0;
  logic [3:0]       ier_i = '0;
  logic [CNT_W-1:0] rx_trig_i = 5'd1;
  logic [CNT_W-1:0] rx_cnt_i = '0;
  logic [3:0]       rx_err_i = '0;
  logic             tx_empty_i = 1'b1;
  logic [3:0]       msr_delta_i = '0;
  logic             tick16_i = 1'b0;
  logic [1:0]       word_len_i = 2'd3;
  logic             parity_en_i = 1'b0;
  logic             stop2_i = 1'b0;
  logic             stop_ctr_i = 1'b0;
  logic             rbr_rd_i = 1'b0;
  logic             isr_rd_i = 1'b0;
  logic             lsr_rd_i = 1'b0;
  logic             msr_rd_i = 1'b0;
  logic             thr_wr_i = 1'b0;
  logic [7:0]       isr_o;
  logic             irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model state
  bit m_line = 0, m_modem = 0, m_thre = 1, m_txq = 1;

  always #5 clk_i = ~clk_i;

  uart_irq_ctrl dut_i (.*);

  task automatic step();
    @(posedge clk_i);
    #2;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_code(logic [3:0] ier, bit ln, bit rd, bit to, bit th, bit md);
    if (ln && ier[2]) return 4'b0110;
    if (rd && ier[0]) return 4'b0100;
    if (to && ier[0]) return 4'b1100;
    if (th && ier[1]) return 4'b0010;
    if (md && ier[3]) return 4'b0000;
    return 4'b0001;
  endfunction

  function automatic bit exp_rd(bit fen, logic [CNT_W-1:0] cnt, logic [CNT_W-1:0] trig);
    return (cnt != 0) && (!fen || cnt >= trig);
  endfunction

  function automatic int tmo_ticks(logic [1:0] wl, bit par, bit s2);
    return 64 * (1 + 5 + int'(wl) + int'(par) + (s2 ? 2 : 1));
  endfunction

  function automatic logic [7:0] exp_isr(bit fen, logic [3:0] code);
    return {{2{fen}}, 2'b00, code};
  endfunction

  task automatic clr_pulses();
    rx_err_i = '0; msr_delta_i = '0; stop_ctr_i = 0; rbr_rd_i = 0;
    isr_rd_i = 0; lsr_rd_i = 0; msr_rd_i = 0; thr_wr_i = 0;
  endtask

  task automatic tmo_run(logic [1:0] wl, bit par, bit s2);
    int lim;
    lim = tmo_ticks(wl, par, s2);
    word_len_i = wl; parity_en_i = par; stop2_i = s2;
    fifo_en_i = 1; ier_i = 4'h1; rx_trig_i = 5'd14; rx_cnt_i = 5'd3;
    stop_ctr_i = 1; step(); stop_ctr_i = 0;
    tick16_i = 1;
    repeat (lim - 1) step();
    check("R8 no timeout one tick early", isr_o, 8'hC1);
    step();
    check("R8 timeout at expiry", isr_o, 8'hCC);
    check("R12 irq with timeout", {7'd0, irq_o}, 8'h01);
    tick16_i = 0;
    rbr_rd_i = 1; step(); rbr_rd_i = 0;
    check("R9 data read clears timeout", isr_o, 8'hC1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #12 rst_ni = 1'b1;
    step();
    // R1 reset state
    check("R1 reset status", isr_o, 8'h01);
    check("R1 reset irq low", {7'd0, irq_o}, 8'h00);
    ier_i = 4'h2; #1;
    check("R1 tx empty pending after reset", isr_o, 8'h02);
    fifo_en_i = 1; #1;
    check("R2 fifo bits set", isr_o, 8'hC2);
    // R7 read while another source is shown does not clear tx empty
    ier_i = 4'hF; rx_err_i = 4'h2; step(); rx_err_i = 0;
    check("R5 line error latched", isr_o, 8'hC6);
    isr_rd_i = 1; step(); isr_rd_i = 0;
    check("R7 status read while line shown", isr_o, 8'hC6);
    lsr_rd_i = 1; step(); lsr_rd_i = 0;
    check("R7 tx empty still pending", isr_o, 8'hC2);
    isr_rd_i = 1; step(); isr_rd_i = 0;
    check("R7 status read clears tx empty", isr_o, 8'hC1);
    check("R12 irq low when none", {7'd0, irq_o}, 8'h00);
    // R4 masked source latched
    ier_i = 4'h0; msr_delta_i = 4'h8; step(); msr_delta_i = 0;
    check("R4 masked modem hidden", isr_o, 8'hC1);
    ier_i = 4'h8; #1;
    check("R11 modem reported once enabled", isr_o, 8'hC0);
    msr_rd_i = 1; step(); msr_rd_i = 0;
    check("R11 modem read clears", isr_o, 8'hC1);
    // R6 trigger levels
    ier_i = 4'h1; rx_trig_i = 5'd8; rx_cnt_i = 5'd7; #1;
    check("R6 below trigger", isr_o, 8'hC1);
    rx_cnt_i = 5'd8; #1;
    check("R6 at trigger", isr_o, 8'hC4);
    fifo_en_i = 0; rx_cnt_i = 5'd1; #1;
    check("R6 non fifo one byte", isr_o, 8'h04);
    check("R2 fifo bits clear", {isr_o[7:6], 6'd0}, 8'h00);
    rx_cnt_i = 0; step();

    // R8 R9 timeout with several line settings
    tmo_run(2'd3, 0, 0);
    tmo_run(2'd0, 1, 1);
    tmo_run(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

    // R9 stop center restarts count
    begin
      int lim;
      lim = tmo_ticks(2'd3, 0, 0);
      word_len_i = 2'd3; parity_en_i = 0; stop2_i = 0;
      rbr_rd_i = 1; step(); rbr_rd_i = 0;
      tick16_i = 1;
      repeat (lim - 10) step();
      tick16_i = 0; stop_ctr_i = 1; step(); stop_ctr_i = 0; tick16_i = 1;
      repeat (lim - 1) step();
      check("R9 stop center restart delays", isr_o, 8'hC1);
      step();
      check("R9 expiry after restart", isr_o, 8'hCC);
      tick16_i = 0;
      // R10 empty FIFO clears and suppresses
      rx_cnt_i = 0; step();
      check("R10 empty clears timeout", isr_o, 8'hC1);
      tick16_i = 1;
      repeat (lim + 5) step();
      check("R10 no timeout when empty", isr_o, 8'hC1);
      tick16_i = 0;
    end
    // R7 rising edge sets, write clears
    tx_empty_i = 0; ier_i = 4'h2; step();
    tx_empty_i = 1; step();
    check("R7 rising edge sets", isr_o, 8'hC2);
    tx_empty_i = 0; thr_wr_i = 1; step(); thr_wr_i = 0;
    check("R7 write clears", isr_o, 8'hC1);
    tx_empty_i = 1; thr_wr_i = 1; step(); thr_wr_i = 0;
    check("R7 write beats rising edge", isr_o, 8'hC1);

    // random mix, no ticks so timeout stays idle
    m_line = 0; m_modem = 0; m_thre = 0; m_txq = 1;
    lsr_rd_i = 1; msr_rd_i = 1; step(); clr_pulses();
    for (int it = 0; it < 600; it++) begin
      logic [3:0] code;
      bit rise;
      fifo_en_i   = 1'($urandom_range(0, 1));
      ier_i       = 4'($urandom);
      rx_cnt_i    = 5'($urandom_range(0, 16));
      case ($urandom_range(0, 3))
        0: rx_trig_i = 5'd1;
        1: rx_trig_i = 5'd4;
        2: rx_trig_i = 5'd8;
        default: rx_trig_i = 5'd14;
      endcase
      rx_err_i    = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
      msr_delta_i = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
      lsr_rd_i    = ($urandom_range(0, 4) == 0);
      msr_rd_i    = ($urandom_range(0, 4) == 0);
      isr_rd_i    = ($urandom_range(0, 3) == 0);
      thr_wr_i    = ($urandom_range(0, 6) == 0);
      tx_empty_i  = 1'($urandom_range(0, 1));
      stop_ctr_i  = ($urandom_range(0, 5) == 0);
      rbr_rd_i    = ($urandom_range(0, 5) == 0);
      #1;
      code = exp_code(ier_i, m_line, exp_rd(fifo_en_i, rx_cnt_i, rx_trig_i), 0, m_thre, m_modem);
      check("R3 R4 random status", isr_o, exp_isr(fifo_en_i, code));
      check("R12 random irq", {7'd0, irq_o}, {7'd0, code != 4'b0001});
      rise = tx_empty_i && !m_txq;
      if (|rx_err_i) m_line = 1; else if (lsr_rd_i) m_line = 0;
      if (|msr_delta_i) m_modem = 1; else if (msr_rd_i) m_modem = 0;
      if (thr_wr_i) m_thre = 0;
      else if (rise) m_thre = 1;
      else if (isr_rd_i && code == 4'b0010) m_thre = 0;
      m_txq = tx_empty_i;
      step();
    end
    clr_pulses();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule